// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block is a serial slave that lets a host read and write a small bank of 32-bit registers. It uses three wires: an active-low select, a serial clock and one shared data line. The host pads the data line outside the block. The block takes the line value in on `sdio_i` and returns `sdio_o` with the enable `sdio_oe` for the pad driver.

Every access is a single fixed frame of 48 serial clocks:

| Clocks | Content |
|---|---|
| 0 to 11 | 12-bit register address, most significant bit first |
| 12 | direction flag: 0 is a write, 1 is a read |
| 13 to 15 | turnaround |
| 16 to 47 | 32-bit data word, bit 31 first |

The host sets the pace of the transfer. There is no valid/ready handshake and no back-pressure: a bit moves on every rising edge of the serial clock while select is low. Select high idles the block, so several slaves can share the clock and data lines. The rest of the chip reads the register contents through a separate parallel port that is independent of the serial clock.

Top module: `spi3w_regbank`

## Requirements
- R1: While `cs_n` is high, serial clock and data activity changes no register and `sdio_oe` stays 0.
- R2: While `cs_n` is low, `sdio_i` is sampled on each rising edge of `sclk`. Rising edges 0..11 shift in address bits 11 down to 0, and edge 12 takes the direction flag (0 write, 1 read).
- R3: During a write, whatever the host drives on edges 13..15 has no effect on the stored word.
- R4: During a write, edges 16..47 shift in data bits 31 down to 0. The addressed register takes the new word at edge 47.
- R5: A write frame that ends, with `cs_n` rising, before edge 47 leaves every register unchanged.
- R6: During a read, `sdio_oe` is 1 only from the falling edge after rising edge 15 through the falling edge after rising edge 47, where it returns to 0. Each data bit changes on a falling edge of `sclk`.
- R7: A read returns the addressed register, bit 31 valid at rising edge 16 and bit 0 at rising edge 47.
- R8: `cs_n` rising clears the bit position and `sdio_oe` at once, without any `sclk` edge. The next frame starts again at address bit 11.
- R9: Only addresses 0..NUM_REGS-1 are implemented, and the full 12-bit address is compared (0x103 does not alias 3). Reads of any other address return 0, and writes to them are dropped.
- R10: `rst_n` low clears every register to 0. `reg_val` always shows the register selected by `reg_sel`, or 0 when `reg_sel` is not implemented.
- R11: Serial clocks beyond the 48th in one frame do nothing, and `sdio_oe` stays 0 during them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of registers and frame state |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock from the host |
| sdio_i | input | 1 | Value seen on the shared data line |
| sdio_o | output | 1 | Read data bit to drive onto the line |
| sdio_oe | output | 1 | Output enable for the data line pad driver |
| reg_sel | input | 12 | Parallel read port address |
| reg_val | output | 32 | Parallel read port data |

## Verification
A wrong bit position shows up within one frame. Either `sdio_oe` rises outside clocks 16..47, or read data appears shifted by one or more bits. A faulty commit strobe or a faulty address decode shows up through `reg_val` straight after the frame that caused it, as a changed word, an aliased register or a missing update. A select-reset fault leaves the enable high after `cs_n` rises, or corrupts the address of the following frame, so the next read returns the wrong register.

// File: rtl/spi3w_pkg.sv
package spi3w_pkg;
  typedef enum logic [2:0] {
    PH_ADDR = 3'd0,
    PH_FLAG = 3'd1,
    PH_TURN = 3'd2,
    PH_DATA = 3'd3,
    PH_DONE = 3'd4
  } phase_e;
endpackage

// File: rtl/spi3w_frame_ctl.sv
module spi3w_frame_ctl
  import spi3w_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int TA_CYC = 3,
  parameter int CNT_W  = 6
) (
  input  logic              sclk,
  input  logic              frame_rst,
  input  logic              sdio_i,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic [ADDR_W-1:0] addr,
  output logic              rd_flag,
  output logic              rd_load,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data
);
  localparam int FLAG_POS  = ADDR_W;
  localparam int DSTART    = ADDR_W + 1 + TA_CYC;
  localparam int FRAME_LEN = DSTART + DATA_W;

  phase_e            phase;
  logic [DATA_W-2:0] dsh;

  // Phase decode from the bit position
  always_comb begin
    if (bit_cnt < CNT_W'(FLAG_POS))        phase = PH_ADDR;
    else if (bit_cnt == CNT_W'(FLAG_POS))  phase = PH_FLAG;
    else if (bit_cnt < CNT_W'(DSTART))     phase = PH_TURN;
    else if (bit_cnt < CNT_W'(FRAME_LEN))  phase = PH_DATA;
    else                                   phase = PH_DONE;
  end

  always_ff @(posedge sclk or posedge frame_rst) begin
    if (frame_rst) begin
      bit_cnt <= '0;
      addr    <= '0;
      rd_flag <= 1'b0;
      dsh     <= '0;
    end else begin
      if (phase != PH_DONE) bit_cnt <= bit_cnt + 1'b1;
      case (phase)
        PH_ADDR: addr    <= {addr[ADDR_W-2:0], sdio_i};
        PH_FLAG: rd_flag <= sdio_i;
        PH_DATA: if (!rd_flag) dsh <= {dsh[DATA_W-3:0], sdio_i};
        default: ;
      endcase
    end
  end

  assign rd_load = (phase == PH_FLAG);
  assign wr_en   = (phase == PH_DATA) && (bit_cnt == CNT_W'(FRAME_LEN - 1)) && !rd_flag;
  assign wr_data = {dsh, sdio_i};
endmodule

// File: rtl/spi3w_regfile.sv
module spi3w_regfile #(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  output logic [DATA_W-1:0] rd_data_b
);
  logic [DATA_W-1:0] regs [NUM_REGS];

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      regs[gi] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(gi))        regs[gi] <= wr_data;
    end
  end

  // Full-width compare: addresses outside the bank read as zero
  always_comb begin
    rd_data_a = '0;
    rd_data_b = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_addr_a == ADDR_W'(i)) rd_data_a = regs[i];
      if (rd_addr_b == ADDR_W'(i)) rd_data_b = regs[i];
    end
  end
endmodule

// File: rtl/spi3w_tx.sv
module spi3w_tx #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6,
  parameter int DSTART = 16
) (
  input  logic              sclk,
  input  logic              frame_rst,
  input  logic              rd_load,
  input  logic [DATA_W-1:0] load_word,
  input  logic              rd_flag,
  input  logic [CNT_W-1:0]  bit_cnt,
  output logic              sdio_o,
  output logic              sdio_oe
);
  localparam int LAST  = DSTART + DATA_W - 1;
  localparam int IDX_W = $clog2(DATA_W);

  logic [DATA_W-1:0] word;
  logic              in_win;
  logic [IDX_W-1:0]  idx;

  always_ff @(posedge sclk or posedge frame_rst) begin
    if (frame_rst)    word <= '0;
    else if (rd_load) word <= load_word;
  end

  assign in_win = rd_flag && (bit_cnt >= CNT_W'(DSTART)) && (bit_cnt <= CNT_W'(LAST));
  assign idx    = IDX_W'(CNT_W'(LAST) - bit_cnt);

  // Launch on the falling edge so the host samples on the next rising edge
  always_ff @(negedge sclk or posedge frame_rst) begin
    if (frame_rst) begin
      sdio_oe <= 1'b0;
      sdio_o  <= 1'b0;
    end else if (in_win) begin
      sdio_oe <= 1'b1;
      sdio_o  <= word[idx];
    end else begin
      sdio_oe <= 1'b0;
      sdio_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/spi3w_regbank.sv
module spi3w_regbank #(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int TA_CYC   = 3,
  parameter int NUM_REGS = 8
) (
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdio_i,
  output logic              sdio_o,
  output logic              sdio_oe,
  input  logic [ADDR_W-1:0] reg_sel,
  output logic [DATA_W-1:0] reg_val
);
  localparam int DSTART    = ADDR_W + 1 + TA_CYC;
  localparam int FRAME_LEN = DSTART + DATA_W;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);

  logic              frame_rst;
  logic [CNT_W-1:0]  bit_cnt;
  logic [ADDR_W-1:0] addr;
  logic              rd_flag;
  logic              rd_load;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_word;

  assign frame_rst = cs_n | ~rst_n;

  spi3w_frame_ctl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TA_CYC(TA_CYC), .CNT_W(CNT_W)
  ) u_ctl (
    .sclk(sclk), .frame_rst(frame_rst), .sdio_i(sdio_i),
    .bit_cnt(bit_cnt), .addr(addr), .rd_flag(rd_flag),
    .rd_load(rd_load), .wr_en(wr_en), .wr_data(wr_data)
  );

  spi3w_regfile #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)
  ) u_rf (
    .clk(sclk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(addr), .wr_data(wr_data),
    .rd_addr_a(addr), .rd_data_a(rd_word),
    .rd_addr_b(reg_sel), .rd_data_b(reg_val)
  );

  spi3w_tx #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .DSTART(DSTART)
  ) u_tx (
    .sclk(sclk), .frame_rst(frame_rst), .rd_load(rd_load),
    .load_word(rd_word), .rd_flag(rd_flag), .bit_cnt(bit_cnt),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe)
  );
endmodule

// File: rtl/spi3w_regbank_chk.sv
module spi3w_regbank_chk #(
  parameter int CNT_W     = 6,
  parameter int DSTART    = 16,
  parameter int FRAME_LEN = 48
) (
  input logic             sclk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             sdio_oe,
  input logic             rd_flag,
  input logic             wr_en,
  input logic [CNT_W-1:0] bit_cnt
);
  assert_oe_idle_R8: assert property (@(posedge sclk) disable iff (!rst_n)
    cs_n |-> !sdio_oe) else $error("driver enabled while deselected");

  assert_oe_window_R6: assert property (@(posedge sclk) disable iff (!rst_n)
    sdio_oe |-> (bit_cnt >= CNT_W'(DSTART) && bit_cnt < CNT_W'(FRAME_LEN)))
    else $error("driver enabled outside data window");

  assert_oe_read_only_R2: assert property (@(posedge sclk) disable iff (!rst_n)
    sdio_oe |-> rd_flag) else $error("driver enabled in a write frame");

  assert_cnt_sat_R11: assert property (@(posedge sclk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(FRAME_LEN)) else $error("bit position past frame end");

  assert_wr_quiet_R3: assert property (@(posedge sclk) disable iff (!rst_n)
    wr_en |-> !sdio_oe) else $error("commit while driving line");

  assert_wr_selected_R5: assert property (@(posedge sclk) disable iff (!rst_n)
    wr_en |-> !cs_n) else $error("commit without select");
endmodule

bind spi3w_regbank spi3w_regbank_chk #(
  .CNT_W(CNT_W), .DSTART(DSTART), .FRAME_LEN(FRAME_LEN)
) u_chk (
  .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .sdio_oe(sdio_oe),
  .rd_flag(rd_flag), .wr_en(wr_en), .bit_cnt(bit_cnt)
);

// File: tb/tb_spi3w_regbank.sv
module tb_spi3w_regbank;
  logic        clk = 1'b0;
  logic        rst_n, cs_n, sclk_en, host_oe, host_bit;
  logic        sclk, line;
  logic        sdio_o, sdio_oe;
  logic [11:0] reg_sel;
  logic [31:0] reg_val;
  int          n_chk = 0;
  int          n_bad = 0;

  always #4 clk = ~clk;
  assign sclk = clk & sclk_en;
  assign line = sdio_oe ? sdio_o : (host_oe ? host_bit : 1'b1);

  spi3w_regbank dut (
    .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdio_i(line),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .reg_sel(reg_sel), .reg_val(reg_val)
  );

  // {read, addr, data, expected}
  localparam int NV = 13;
  localparam logic [76:0] VEC [NV] = '{
    {1'b0, 12'h000, 32'hA5A5_0F0F, 32'hA5A5_0F0F},
    {1'b0, 12'h003, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {1'b0, 12'h007, 32'h1234_5678, 32'h1234_5678},
    {1'b0, 12'h103, 32'hFFFF_FFFF, 32'h0000_0000},
    {1'b1, 12'h003, 32'h0,         32'hDEAD_BEEF},
    {1'b1, 12'h000, 32'h0,         32'hA5A5_0F0F},
    {1'b1, 12'h007, 32'h0,         32'h1234_5678},
    {1'b1, 12'h103, 32'h0,         32'h0000_0000},
    {1'b1, 12'h005, 32'h0,         32'h0000_0000},
    {1'b0, 12'h005, 32'h8000_0001, 32'h8000_0001},
    {1'b1, 12'h005, 32'h0,         32'h8000_0001},
    {1'b0, 12'h7FF, 32'h5555_AAAA, 32'h0000_0000},
    {1'b1, 12'h008, 32'h0,         32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic port_val(input logic [11:0] a, output logic [31:0] v);
    reg_sel = a;
    #1;
    v = reg_val;
  endtask

  // One frame of nclk serial clocks; select rises at the falling edge after the last one
  task automatic run_frame(input logic rd, input logic [11:0] a, input logic [31:0] d,
                           input int nclk, output logic [31:0] got, output logic oe_bad);
    got = '0;
    oe_bad = 1'b0;
    @(negedge clk);
    cs_n = 1'b0;
    for (int i = 0; i < nclk; i++) begin
      @(negedge clk);
      sclk_en = 1'b1;
      if (i < 12)       begin host_oe = 1'b1; host_bit = a[11-i]; end
      else if (i == 12) begin host_oe = 1'b1; host_bit = rd; end
      else if (i < 16)  begin host_oe = !rd;  host_bit = i[0]; end
      else if (i < 48)  begin host_oe = !rd;  host_bit = d[47-i]; end
      else              begin host_oe = 1'b0; host_bit = 1'b0; end
      @(posedge clk);
      #2;
      if (sdio_oe !== (rd && i >= 16 && i <= 47)) oe_bad = 1'b1;
      if (sdio_oe && host_oe) oe_bad = 1'b1;
      if (rd && i >= 16 && i < 48) got[47-i] = sdio_o;
    end
    @(negedge clk);
    sclk_en = 1'b0;
    host_oe = 1'b0;
    cs_n = 1'b1;
    #1;
    if (sdio_oe !== 1'b0) oe_bad = 1'b1;
    @(negedge clk);
  endtask

  task automatic report;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    report();
  end

  initial begin
    logic [31:0] v, got;
    logic        bad;
    rst_n = 1'b0; cs_n = 1'b1; sclk_en = 1'b0; host_oe = 1'b0; host_bit = 1'b0;
    reg_sel = '0;
    #20;
    rst_n = 1'b1;
    #10;

    // R10: reset state of every register and of the driver
    for (int k = 0; k < 8; k++) begin
      port_val(12'(k), v);
      chk("R10 reset value", v, 32'h0);
    end
    chk("R6 idle oe", {31'h0, sdio_oe}, 32'h0);

    // Vector table: writes checked at the parallel port, reads on the line
    for (int k = 0; k < NV; k++) begin
      run_frame(VEC[k][76], VEC[k][75:64], VEC[k][63:32], 48, got, bad);
      chk("R6 R2 oe window", {31'h0, bad}, 32'h0);
      if (VEC[k][76]) begin
        chk("R7 R9 read data", got, VEC[k][31:0]);
      end else begin
        port_val(VEC[k][75:64], v);
        chk("R4 R3 R9 write via port", v, VEC[k][31:0]);
      end
    end
    port_val(12'h003, v);
    chk("R9 no alias 0x103->3", v, 32'hDEAD_BEEF);

    // R5: write cut one clock short is discarded
    run_frame(1'b0, 12'h001, 32'h1111_2222, 47, got, bad);
    port_val(12'h001, v);
    chk("R5 short write dropped", v, 32'h0);
    run_frame(1'b0, 12'h001, 32'h3333_4444, 48, got, bad);
    port_val(12'h001, v);
    chk("R4 full write", v, 32'h3333_4444);

    // R11: extra clocks after the frame change nothing and keep driver off
    run_frame(1'b0, 12'h002, 32'hCAFE_F00D, 52, got, bad);
    chk("R11 oe quiet past frame", {31'h0, bad}, 32'h0);
    port_val(12'h002, v);
    chk("R11 long write value", v, 32'hCAFE_F00D);
    run_frame(1'b1, 12'h002, 32'h0, 52, got, bad);
    chk("R11 long read oe", {31'h0, bad}, 32'h0);
    chk("R11 long read data", got, 32'hCAFE_F00D);

    // R8: abort a read mid-data; driver must drop at once
    run_frame(1'b1, 12'h003, 32'h0, 31, got, bad);
    chk("R8 abort oe drop", {31'h0, bad}, 32'h0);
    chk("R8 partial bits", {got[31:17], 17'h0}, {32'hDEAD_BEEF & 32'hFFFE_0000});
    run_frame(1'b1, 12'h007, 32'h0, 48, got, bad);
    chk("R8 next frame realigned", got, 32'h1234_5678);

    // R1: clocks and data with select high are ignored
    @(negedge clk);
    for (int i = 0; i < 48; i++) begin
      @(negedge clk);
      sclk_en = 1'b1; host_oe = 1'b1;
      host_bit = (i >= 16) ? 1'b1 : 1'b0;
      @(posedge clk);
      #2;
      if (sdio_oe !== 1'b0) bad = 1'b1;
    end
    @(negedge clk);
    sclk_en = 1'b0; host_oe = 1'b0;
    port_val(12'h000, v);
    chk("R1 deselected ignored", v, 32'hA5A5_0F0F);
    chk("R1 oe off deselected", {31'h0, sdio_oe}, 32'h0);

    // R10: reset clears the bank after use
    rst_n = 1'b0;
    #10;
    rst_n = 1'b1;
    #5;
    port_val(12'h007, v);
    chk("R10 reset clears", v, 32'h0);

    report();
  end
endmodule